// File: doc/BRIEF.md
# ATA Command Transfer Plan Decoder

This block sits between the latched ATA command registers of a device controller and the state machine that runs the command. It takes one command per cycle over a valid/ready handshake. Each command is an opcode, a 16-bit sector count and a 48-bit LBA. One cycle later it presents a registered transfer plan. The plan gives the number of sectors to move and the data direction. It says whether data-request phases occur at all. It gives the interrupt grouping as the sectors per interrupt and the size of the final group. Two flags report a rejected command and an address-range rejection.

The decoder also holds two pieces of device state that shape later plans. The first is the block size used by the read/write multiple commands, which the set-multiple command changes. The second is the maximum user LBA, which the set-max-address commands change. Every read, write and verify is checked against the maximum LBA. Both values are visible on output ports, so the identify responder can report the current capacity and block size.

Top module: `ata_xfer_decoder`

## Requirements
- R1: 28-bit sector, DMA and multiple commands (20h, 21h, 30h, 31h, C8h, C9h, CAh, CBh, C4h, C5h, 40h, 41h) use only the low count byte. A low byte of 0 means 256 sectors. The upper count byte is ignored.
- R2: EXT commands (24h, 25h, 34h, 35h, 29h, 39h, 42h) use the full 16-bit count, and a count of 0 means 65536 sectors.
- R3: plan_dir encodes 0 for no data, 1 for device-to-host and 2 for host-to-device. Reads use 1 and writes use 2, each with plan_drq=1. Single-sector PIO commands interrupt every sector (plan_irq_blk=plan_last_blk=1). DMA commands (25h, 35h, C8h to CBh) interrupt once (plan_irq_blk=plan_last_blk=plan_sectors).
- R4: Verify commands (40h, 41h, 42h) report the decoded sector count with plan_dir=0, plan_drq=0 and a single interrupt at the end.
- R5: Multiple commands (C4h, C5h, 29h, 39h) set plan_irq_blk to the current block size. plan_last_blk is the remainder of sectors divided by the block size, or the full block size when the remainder is zero. The block size after reset is 16.
- R6: Set-multiple (C6h) takes its block size from the low count byte. A size that is a nonzero power of two no larger than 16 is stored and appears on mult_blk. Any other size aborts the command and leaves mult_blk unchanged.
- R7: Opcode 00h always produces plan_abort=1.
- R8: An opcode outside the decoded set produces plan_abort=1 with zero sectors, plan_dir=0 and plan_drq=0. Every aborted plan has these zero fields.
- R9: Set-max (F9h uses LBA bits 27:0; 37h uses all 48 bits) stores a new maximum that appears on max_lba. A value above the native maximum aborts the command and changes nothing. A read, write or verify whose last LBA (start plus sectors minus 1) exceeds max_lba gives plan_abort=1 and plan_idnf=1. 28-bit commands ignore LBA bits 47:28.
- R10: Download microcode (92h) moves {LBA bits 7:0, count bits 7:0} sectors host-to-device, as one group. plan_drq is 0 when the length is zero.
- R11: cmd_ready is high when no plan is pending or plan_ready is high. A pending plan with plan_ready low holds all its fields.
- R12: After reset, plan_valid=0, mult_blk=16 and max_lba equals the native maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Decoder can take a command this cycle |
| cmd_opcode | input | 8 | Command opcode |
| cmd_count | input | 16 | Sector count register (16-bit for EXT commands) |
| cmd_lba | input | 48 | LBA register |
| plan_ready | input | 1 | Consumer takes the pending plan |
| plan_valid | output | 1 | Plan pending |
| plan_sectors | output | 17 | Total sectors in the command |
| plan_dir | output | 2 | Data direction: 0 none, 1 to host, 2 from host |
| plan_drq | output | 1 | Data-request phases occur |
| plan_irq_blk | output | 17 | Sectors per interrupt group |
| plan_last_blk | output | 17 | Sectors in the final interrupt group |
| plan_abort | output | 1 | Command is rejected |
| plan_idnf | output | 1 | Rejection is due to the address range |
| mult_blk | output | 8 | Current multiple-mode block size |
| max_lba | output | 48 | Current maximum user LBA |

## Verification
The bench builds the decoder with a native maximum LBA of 70000 instead of a full drive capacity. With that value, a 65536-sector EXT transfer, an address-range rejection one sector past the limit, and a set-max request one above the native maximum all fit in a few directed commands. The default multiple-mode size of 16 is kept. At that size, partial final groups, exact multiples and the largest allowed set-multiple value all sit within ordinary 8-bit counts.

// File: rtl/ata_dec_pkg.sv
package ata_dec_pkg;

  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_IN   = 2'd1,
    DIR_OUT  = 2'd2
  } dir_e;

  typedef enum logic [3:0] {
    K_UNKNOWN = 4'd0,
    K_NOP     = 4'd1,
    K_XFER    = 4'd2,
    K_VERIFY  = 4'd3,
    K_MULT    = 4'd4,
    K_UCODE   = 4'd5,
    K_SETMULT = 4'd6,
    K_SETMAX  = 4'd7,
    K_NODATA  = 4'd8
  } kind_e;

  typedef struct packed {
    kind_e kind;
    dir_e  dir;
    logic  ext;
    logic  dma;
  } op_info_t;

  function automatic op_info_t mk_info(kind_e k, dir_e d, logic e, logic m);
    op_info_t r;
    r.kind = k;
    r.dir  = d;
    r.ext  = e;
    r.dma  = m;
    return r;
  endfunction

endpackage

// File: rtl/ata_op_classify.sv
module ata_op_classify
  import ata_dec_pkg::*;
(
  input  logic [7:0] opcode,
  output op_info_t   info
);

  always_comb begin
    case (opcode)
      8'h20, 8'h21: info = mk_info(K_XFER,    DIR_IN,   1'b0, 1'b0);
      8'h24:        info = mk_info(K_XFER,    DIR_IN,   1'b1, 1'b0);
      8'h25:        info = mk_info(K_XFER,    DIR_IN,   1'b1, 1'b1);
      8'h30, 8'h31: info = mk_info(K_XFER,    DIR_OUT,  1'b0, 1'b0);
      8'h34:        info = mk_info(K_XFER,    DIR_OUT,  1'b1, 1'b0);
      8'h35:        info = mk_info(K_XFER,    DIR_OUT,  1'b1, 1'b1);
      8'hC8, 8'hC9: info = mk_info(K_XFER,    DIR_IN,   1'b0, 1'b1);
      8'hCA, 8'hCB: info = mk_info(K_XFER,    DIR_OUT,  1'b0, 1'b1);
      8'h40, 8'h41: info = mk_info(K_VERIFY,  DIR_NONE, 1'b0, 1'b0);
      8'h42:        info = mk_info(K_VERIFY,  DIR_NONE, 1'b1, 1'b0);
      8'hC4:        info = mk_info(K_MULT,    DIR_IN,   1'b0, 1'b0);
      8'hC5:        info = mk_info(K_MULT,    DIR_OUT,  1'b0, 1'b0);
      8'h29:        info = mk_info(K_MULT,    DIR_IN,   1'b1, 1'b0);
      8'h39:        info = mk_info(K_MULT,    DIR_OUT,  1'b1, 1'b0);
      8'h92:        info = mk_info(K_UCODE,   DIR_OUT,  1'b0, 1'b0);
      8'hC6:        info = mk_info(K_SETMULT, DIR_NONE, 1'b0, 1'b0);
      8'hF9:        info = mk_info(K_SETMAX,  DIR_NONE, 1'b0, 1'b0);
      8'h37:        info = mk_info(K_SETMAX,  DIR_NONE, 1'b1, 1'b0);
      8'h00:        info = mk_info(K_NOP,     DIR_NONE, 1'b0, 1'b0);
      8'hE0, 8'hE1, 8'hE2, 8'hE3,
      8'hE5, 8'hE6, 8'hE7, 8'hEA:
                    info = mk_info(K_NODATA,  DIR_NONE, 1'b0, 1'b0);
      default:      info = mk_info(K_UNKNOWN, DIR_NONE, 1'b0, 1'b0);
    endcase
  end

endmodule

// File: rtl/ata_count_calc.sv
module ata_count_calc
  import ata_dec_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int MULT_W = 8,
  localparam int SEC_W = CNT_W + 1
) (
  input  op_info_t           info,
  input  logic [CNT_W-1:0]   count,
  input  logic [7:0]         lba_low,
  input  logic [MULT_W-1:0]  mult_blk,
  output logic [SEC_W-1:0]   sectors,
  output logic [SEC_W-1:0]   irq_blk,
  output logic [SEC_W-1:0]   last_blk,
  output dir_e               dir,
  output logic               drq
);

  logic [SEC_W-1:0] sec_raw;
  logic [SEC_W-1:0] ucode_len;
  logic [SEC_W-1:0] mult_ext;
  logic [SEC_W-1:0] rem;

  always_comb begin
    if (info.ext)
      sec_raw = (count == '0) ? (SEC_W'(1) << CNT_W) : SEC_W'(count);
    else
      sec_raw = (count[7:0] == 8'd0) ? SEC_W'(256) : SEC_W'(count[7:0]);
    ucode_len = SEC_W'({lba_low, count[7:0]});
    mult_ext  = SEC_W'(mult_blk);
    rem       = sec_raw & (mult_ext - SEC_W'(1));
  end

  always_comb begin
    sectors  = '0;
    irq_blk  = '0;
    last_blk = '0;
    dir      = DIR_NONE;
    drq      = 1'b0;
    case (info.kind)
      K_XFER: begin
        sectors  = sec_raw;
        dir      = info.dir;
        drq      = 1'b1;
        irq_blk  = info.dma ? sec_raw : SEC_W'(1);
        last_blk = info.dma ? sec_raw : SEC_W'(1);
      end
      K_VERIFY: begin
        sectors  = sec_raw;
        irq_blk  = sec_raw;
        last_blk = sec_raw;
      end
      K_MULT: begin
        sectors  = sec_raw;
        dir      = info.dir;
        drq      = 1'b1;
        irq_blk  = mult_ext;
        last_blk = (rem == '0) ? mult_ext : rem;
      end
      K_UCODE: begin
        sectors  = ucode_len;
        dir      = DIR_OUT;
        drq      = (ucode_len != '0);
        irq_blk  = ucode_len;
        last_blk = ucode_len;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ata_range_chk.sv
module ata_range_chk #(
  parameter int LBA_W = 48,
  parameter int SEC_W = 17,
  localparam int EW   = LBA_W + 1
) (
  input  logic             ext,
  input  logic [LBA_W-1:0] lba,
  input  logic [SEC_W-1:0] sectors,
  input  logic [LBA_W-1:0] max_lba,
  output logic             out_of_range
);

  logic [LBA_W-1:0] start;
  logic [EW-1:0]    end_lba;

  always_comb begin
    start        = ext ? lba : LBA_W'(lba[27:0]);
    end_lba      = {1'b0, start} + EW'(sectors) - EW'(1);
    out_of_range = (sectors != '0) && (end_lba > {1'b0, max_lba});
  end

endmodule

// File: rtl/ata_dec_state.sv
module ata_dec_state
  import ata_dec_pkg::*;
#(
  parameter int               LBA_W      = 48,
  parameter int               MULT_W     = 8,
  parameter int               MULT_DEF   = 16,
  parameter logic [LBA_W-1:0] NATIVE_MAX = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  kind_e             kind,
  input  logic              ext,
  input  logic [MULT_W-1:0] req_blk,
  input  logic [LBA_W-1:0]  lba,
  output logic              setmult_bad,
  output logic              setmax_bad,
  output logic [MULT_W-1:0] mult_blk,
  output logic [LBA_W-1:0]  max_lba
);

  logic [MULT_W-1:0] mult_q;
  logic [LBA_W-1:0]  max_q;
  logic [LBA_W-1:0]  new_max;
  logic              mult_en;
  logic              max_en;

  always_comb begin
    setmult_bad = (req_blk == '0) ||
                  ((req_blk & (req_blk - MULT_W'(1))) != '0) ||
                  (req_blk > MULT_W'(MULT_DEF));
    new_max     = ext ? lba : LBA_W'(lba[27:0]);
    setmax_bad  = (new_max > NATIVE_MAX);
    mult_en     = accept && (kind == K_SETMULT) && !setmult_bad;
    max_en      = accept && (kind == K_SETMAX) && !setmax_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mult_q <= MULT_W'(MULT_DEF);
      max_q  <= NATIVE_MAX;
    end else begin
      if (mult_en) mult_q <= req_blk;
      if (max_en)  max_q  <= new_max;
    end
  end

  assign mult_blk = mult_q;
  assign max_lba  = max_q;

  // R6
  mult_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(mult_q) == 1) && (mult_q <= MULT_W'(MULT_DEF)));

  // R6
  mult_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mult_q) |-> $past(accept && (kind == K_SETMULT)));

  // R9
  max_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    max_q <= NATIVE_MAX);

  // R9
  max_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(max_q) |-> $past(accept && (kind == K_SETMAX)));

endmodule

// File: rtl/ata_xfer_decoder.sv
module ata_xfer_decoder
  import ata_dec_pkg::*;
#(
  parameter int                LBA_W          = 48,
  parameter int                CNT_W          = 16,
  parameter int                MULT_W         = 8,
  parameter int                MULT_DEF       = 16,
  parameter logic [LBA_W-1:0]  NATIVE_MAX_LBA = 48'h0000_37E4_36AF,
  localparam int               SEC_W          = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [7:0]        cmd_opcode,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic [LBA_W-1:0]  cmd_lba,
  input  logic              plan_ready,
  output logic              plan_valid,
  output logic [SEC_W-1:0]  plan_sectors,
  output logic [1:0]        plan_dir,
  output logic              plan_drq,
  output logic [SEC_W-1:0]  plan_irq_blk,
  output logic [SEC_W-1:0]  plan_last_blk,
  output logic              plan_abort,
  output logic              plan_idnf,
  output logic [MULT_W-1:0] mult_blk,
  output logic [LBA_W-1:0]  max_lba
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  op_info_t         info;
  logic [SEC_W-1:0] c_sectors, c_irq, c_last;
  dir_e             c_dir;
  logic             c_drq;
  logic             oor;
  logic             setmult_bad, setmax_bad;
  logic             accept;

  ata_op_classify u_cls (
    .opcode (cmd_opcode),
    .info   (info)
  );

  ata_count_calc #(.CNT_W(CNT_W), .MULT_W(MULT_W)) u_cnt (
    .info     (info),
    .count    (cmd_count),
    .lba_low  (cmd_lba[7:0]),
    .mult_blk (mult_blk),
    .sectors  (c_sectors),
    .irq_blk  (c_irq),
    .last_blk (c_last),
    .dir      (c_dir),
    .drq      (c_drq)
  );

  ata_range_chk #(.LBA_W(LBA_W), .SEC_W(SEC_W)) u_rng (
    .ext          (info.ext),
    .lba          (cmd_lba),
    .sectors      (c_sectors),
    .max_lba      (max_lba),
    .out_of_range (oor)
  );

  ata_dec_state #(
    .LBA_W(LBA_W), .MULT_W(MULT_W), .MULT_DEF(MULT_DEF), .NATIVE_MAX(NATIVE_MAX_LBA)
  ) u_st (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .accept      (accept),
    .kind        (info.kind),
    .ext         (info.ext),
    .req_blk     (cmd_count[MULT_W-1:0]),
    .lba         (cmd_lba),
    .setmult_bad (setmult_bad),
    .setmax_bad  (setmax_bad),
    .mult_blk    (mult_blk),
    .max_lba     (max_lba)
  );

  // plan registers
  logic             valid_q, valid_d;
  logic [SEC_W-1:0] sec_q, sec_d, irq_q, irq_d, last_q, last_d;
  dir_e             dir_q, dir_d;
  logic             drq_q, drq_d, abort_q, abort_d, idnf_q, idnf_d;
  logic             ranged;

  assign cmd_ready = rst_n_s && (!valid_q || plan_ready);
  assign accept    = cmd_valid && cmd_ready;

  always_comb begin
    ranged  = (info.kind == K_XFER) || (info.kind == K_VERIFY) || (info.kind == K_MULT);
    idnf_d  = ranged && oor;
    abort_d = (info.kind == K_UNKNOWN) || (info.kind == K_NOP) ||
              ((info.kind == K_SETMULT) && setmult_bad) ||
              ((info.kind == K_SETMAX) && setmax_bad) || idnf_d;
    sec_d   = c_sectors;
    irq_d   = c_irq;
    last_d  = c_last;
    dir_d   = c_dir;
    drq_d   = c_drq;
    if (abort_d) begin
      sec_d  = '0;
      irq_d  = '0;
      last_d = '0;
      dir_d  = DIR_NONE;
      drq_d  = 1'b0;
    end
    if (accept)          valid_d = 1'b1;
    else if (plan_ready) valid_d = 1'b0;
    else                 valid_d = valid_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      valid_q <= 1'b0;
      sec_q   <= '0;
      irq_q   <= '0;
      last_q  <= '0;
      dir_q   <= DIR_NONE;
      drq_q   <= 1'b0;
      abort_q <= 1'b0;
      idnf_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (accept) begin
        sec_q   <= sec_d;
        irq_q   <= irq_d;
        last_q  <= last_d;
        dir_q   <= dir_d;
        drq_q   <= drq_d;
        abort_q <= abort_d;
        idnf_q  <= idnf_d;
      end
    end
  end

  assign plan_valid    = valid_q;
  assign plan_sectors  = sec_q;
  assign plan_irq_blk  = irq_q;
  assign plan_last_blk = last_q;
  assign plan_dir      = dir_q;
  assign plan_drq      = drq_q;
  assign plan_abort    = abort_q;
  assign plan_idnf     = idnf_q;

  // R11
  plan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (plan_valid && !plan_ready) |=> (plan_valid && $stable(plan_sectors) &&
                                     $stable(plan_abort) && $stable(plan_dir)));

  // R8
  abort_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (plan_valid && plan_abort) |-> (plan_sectors == '0 && plan_dir == 2'd0 && !plan_drq));

  // R3
  drq_dir_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (plan_valid && plan_drq) |-> (plan_dir != 2'd0));

  // R5
  last_blk_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    plan_valid |-> (plan_last_blk <= plan_irq_blk));

  // R9
  idnf_abort_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (plan_valid && plan_idnf) |-> plan_abort);

endmodule

// File: tb/ata_xfer_decoder_tb.sv
module ata_xfer_decoder_tb;

  localparam int          CLK_PERIOD = 10;
  localparam logic [47:0] NMAX       = 48'd70000;

  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [7:0]  cmd_opcode;
  logic [15:0] cmd_count;
  logic [47:0] cmd_lba;
  logic        plan_ready;
  logic        plan_valid;
  logic [16:0] plan_sectors;
  logic [1:0]  plan_dir;
  logic        plan_drq;
  logic [16:0] plan_irq_blk;
  logic [16:0] plan_last_blk;
  logic        plan_abort;
  logic        plan_idnf;
  logic [7:0]  mult_blk;
  logic [47:0] max_lba;

  int n_checks = 0;
  int n_fails  = 0;

  ata_xfer_decoder #(.NATIVE_MAX_LBA(NMAX)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_opcode(cmd_opcode), .cmd_count(cmd_count), .cmd_lba(cmd_lba),
    .plan_ready(plan_ready), .plan_valid(plan_valid),
    .plan_sectors(plan_sectors), .plan_dir(plan_dir), .plan_drq(plan_drq),
    .plan_irq_blk(plan_irq_blk), .plan_last_blk(plan_last_blk),
    .plan_abort(plan_abort), .plan_idnf(plan_idnf),
    .mult_blk(mult_blk), .max_lba(max_lba)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [7:0] op, input logic [15:0] cnt, input logic [47:0] lba);
    @(negedge clk);
    cmd_opcode = op;
    cmd_count  = cnt;
    cmd_lba    = lba;
    cmd_valid  = 1'b1;
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_plan(input string tag, input int sec, input int dir, input bit drq,
                             input int irq, input int last, input bit ab, input bit idnf);
    chk({tag, " valid"},  64'(plan_valid),    64'd1);
    chk({tag, " sectors"}, 64'(plan_sectors), 64'(sec));
    chk({tag, " dir"},    64'(plan_dir),      64'(dir));
    chk({tag, " drq"},    64'(plan_drq),      64'(drq));
    chk({tag, " irq"},    64'(plan_irq_blk),  64'(irq));
    chk({tag, " last"},   64'(plan_last_blk), 64'(last));
    chk({tag, " abort"},  64'(plan_abort),    64'(ab));
    chk({tag, " idnf"},   64'(plan_idnf),     64'(idnf));
  endtask

  task automatic t_reset();
    chk("R12 plan_valid", 64'(plan_valid), 64'd0);
    chk("R12 cmd_ready",  64'(cmd_ready),  64'd1);
    chk("R12 mult_blk",   64'(mult_blk),   64'd16);
    chk("R12 max_lba",    64'(max_lba),    64'(NMAX));
  endtask

  task automatic t_count28();
    issue(8'h20, 16'h0000, 48'd0);
    expect_plan("R1 R3 read 28 zero", 256, 1, 1, 1, 1, 0, 0);
    issue(8'h30, 16'h1205, 48'd10);
    expect_plan("R1 R3 write 28 upper byte", 5, 2, 1, 1, 1, 0, 0);
    issue(8'hC8, 16'h0003, 48'd0);
    expect_plan("R3 dma read 28", 3, 1, 1, 3, 3, 0, 0);
  endtask

  task automatic t_count48();
    issue(8'h24, 16'h0000, 48'd0);
    expect_plan("R2 read ext zero", 65536, 1, 1, 1, 1, 0, 0);
    issue(8'h35, 16'h1234, 48'd0);
    expect_plan("R2 R3 dma write ext", 4660, 2, 1, 4660, 4660, 0, 0);
  endtask

  task automatic t_verify();
    issue(8'h40, 16'h0000, 48'd0);
    expect_plan("R4 verify 28", 256, 0, 0, 256, 256, 0, 0);
    issue(8'h42, 16'd1000, 48'd0);
    expect_plan("R4 verify ext", 1000, 0, 0, 1000, 1000, 0, 0);
  endtask

  task automatic t_multiple();
    issue(8'hC4, 16'd40, 48'd0);
    expect_plan("R5 mult partial", 40, 1, 1, 16, 8, 0, 0);
    issue(8'h29, 16'd32, 48'd0);
    expect_plan("R5 mult exact", 32, 1, 1, 16, 16, 0, 0);
    issue(8'hC5, 16'd5, 48'd0);
    expect_plan("R5 mult short", 5, 2, 1, 16, 5, 0, 0);
  endtask

  task automatic t_setmult();
    issue(8'hC6, 16'd4, 48'd0);
    expect_plan("R6 setmult ok", 0, 0, 0, 0, 0, 0, 0);
    chk("R6 mult_blk after 4", 64'(mult_blk), 64'd4);
    issue(8'hC4, 16'd10, 48'd0);
    expect_plan("R6 R5 mult with 4", 10, 1, 1, 4, 2, 0, 0);
    issue(8'hC6, 16'd6, 48'd0);
    chk("R6 setmult 6 abort", 64'(plan_abort), 64'd1);
    chk("R6 mult_blk kept 6", 64'(mult_blk), 64'd4);
    issue(8'hC6, 16'd32, 48'd0);
    chk("R6 setmult 32 abort", 64'(plan_abort), 64'd1);
    chk("R6 mult_blk kept 32", 64'(mult_blk), 64'd4);
    issue(8'hC6, 16'd0, 48'd0);
    chk("R6 setmult 0 abort", 64'(plan_abort), 64'd1);
    issue(8'hC6, 16'd16, 48'd0);
    chk("R6 setmult 16 ok", 64'(plan_abort), 64'd0);
    chk("R6 mult_blk 16", 64'(mult_blk), 64'd16);
  endtask

  task automatic t_abort();
    issue(8'h00, 16'd7, 48'd0);
    expect_plan("R7 nop", 0, 0, 0, 0, 0, 1, 0);
    issue(8'hFF, 16'd9, 48'd3);
    expect_plan("R8 unknown", 0, 0, 0, 0, 0, 1, 0);
    issue(8'hE7, 16'd9, 48'd3);
    expect_plan("R8 known non-data", 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_range();
    issue(8'hF9, 16'd0, 48'd1000);
    expect_plan("R9 setmax 28", 0, 0, 0, 0, 0, 0, 0);
    chk("R9 max_lba 1000", 64'(max_lba), 64'd1000);
    issue(8'h20, 16'd2, 48'd999);
    expect_plan("R9 end at max", 2, 1, 1, 1, 1, 0, 0);
    issue(8'h20, 16'd3, 48'd999);
    expect_plan("R9 past max", 0, 0, 0, 0, 0, 1, 1);
    issue(8'h20, 16'd1, 48'h0000_1000_0005);
    expect_plan("R9 28-bit upper lba ignored", 1, 1, 1, 1, 1, 0, 0);
    issue(8'h24, 16'd1, 48'h0000_1000_0005);
    expect_plan("R9 ext upper lba used", 0, 0, 0, 0, 0, 1, 1);
    issue(8'h37, 16'd0, 48'd70001);
    chk("R9 setmax above native abort", 64'(plan_abort), 64'd1);
    chk("R9 max_lba kept", 64'(max_lba), 64'd1000);
    issue(8'h37, 16'd0, 48'd70000);
    chk("R9 setmax ext ok", 64'(plan_abort), 64'd0);
    chk("R9 max_lba 70000", 64'(max_lba), 64'd70000);
    issue(8'h24, 16'd2, 48'd69999);
    expect_plan("R9 ext end at max", 2, 1, 1, 1, 1, 0, 0);
    issue(8'h42, 16'd3, 48'd69999);
    expect_plan("R9 verify past max", 0, 0, 0, 0, 0, 1, 1);
  endtask

  task automatic t_ucode();
    issue(8'h92, 16'hAB02, 48'h0000_0000_0001);
    expect_plan("R10 microcode 258", 258, 2, 1, 258, 258, 0, 0);
    issue(8'h92, 16'h0000, 48'd0);
    expect_plan("R10 microcode zero", 0, 2, 0, 0, 0, 0, 0);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    plan_ready = 1'b0;
    issue(8'h20, 16'd7, 48'd0);
    chk("R11 plan pending", 64'(plan_valid), 64'd1);
    chk("R11 ready low", 64'(cmd_ready), 64'd0);
    cmd_opcode = 8'h20;
    cmd_count  = 16'd9;
    cmd_lba    = 48'd0;
    cmd_valid  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R11 sectors held", 64'(plan_sectors), 64'd7);
    chk("R11 valid held", 64'(plan_valid), 64'd1);
    plan_ready = 1'b1;
    #1;
    chk("R11 ready returns", 64'(cmd_ready), 64'd1);
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
    @(negedge clk);
    chk("R11 next plan", 64'(plan_sectors), 64'd9);
    @(negedge clk);
    chk("R11 plan drained", 64'(plan_valid), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fails++;
    $display("FAIL watchdog: all requirements, actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    cmd_valid  = 1'b0;
    cmd_opcode = 8'h00;
    cmd_count  = 16'h0000;
    cmd_lba    = 48'd0;
    plan_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_count28();
    t_count48();
    t_verify();
    t_multiple();
    t_setmult();
    t_abort();
    t_range();
    t_ucode();
    t_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule